// File: doc/BRIEF.md
# Peripheral Gate Register Bank

This block is the register file a system controller uses to hold peripherals in reset and to switch them on. Software sees an array of 32-bit words. One group of consecutive words controls per-peripheral reset lines. A second, separate group controls per-peripheral enable lines. The remaining words in the valid range are plain storage. Each bit of a group word owns one output line. Its line number is the word's position inside its group times 32, plus the bit position.

Output lines do not simply mirror the stored words. Each line is a flip-flop that moves only when a write produces a qualifying transition against the word's previous contents. A reset line is released (driven low) only when its bit goes from 1 to 0. An enable line is asserted (driven high) only when its bit goes from 0 to 1. Every other change leaves the line where it is. Reset lines come up high, so peripherals start held in reset. Enable lines come up low. A write always stores the whole word. To release a peripheral that has just come out of block reset, software first writes its bit to 1 and then writes it to 0.

The bus port is a single request per cycle with a byte address. Each request is answered by a response strobe one cycle later, which carries read data and an error flag for addresses beyond the last word.

Top module: `periph_gate_bank`

## Requirements
- R1: After block reset, every register reads zero, every reset line is 1, every enable line is 0, and no response is pending.
- R2: The word index is the byte address shifted right by two, so the low two address bits are ignored. Every request gets `respValid` high exactly one cycle later, with read data in that same cycle.
- R3: An index of 24 or more (byte address 0x60 and up, by default) returns `respErr` high with `respValid`, and read data zero. A write to such an address changes no register and no line.
- R4: Reset words sit at indices 4 to 8 (bytes 0x10 to 0x23). In these words, a write that takes bit b of index i from 1 to 0 drives reset line (i-4)*32+b to 0 from the next cycle on.
- R5: A 0-to-1 change of a reset-word bit leaves its reset line unchanged. A reset line never goes from 0 back to 1 except through block reset.
- R6: Enable words sit at indices 12 to 16 (bytes 0x30 to 0x43). In these words, a write that takes bit b of index i from 0 to 1 drives enable line (i-12)*32+b to 1 from the next cycle on.
- R7: A 1-to-0 change of an enable-word bit leaves its enable line unchanged. An enable line never falls except through block reset.
- R8: A write to any valid index stores the full 32-bit word, and a later read returns it, whether or not any line moved.
- R9: Indices 0-3, 9-11 and 17-23 are plain storage. Writing or reading them never changes any line.
- R10: A transition is judged against the word held just before the write. Writing 0 to a reset word that already holds 0 releases nothing, and repeating a write of the same value moves no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| reqValid | input | 1 | Request strobe, one request per cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 8 | Byte address |
| reqWdata | input | 32 | Write data |
| respValid | output | 1 | Response strobe, one cycle after the request |
| respErr | output | 1 | Out-of-range access flag, valid with respValid |
| respRdata | output | 32 | Read data, valid with respValid |
| rstLines | output | 160 | Peripheral reset lines, line n = group word n/32, bit n%32 |
| enLines | output | 160 | Peripheral enable lines, same numbering |

## Verification
The transition logic is driven with words that set and clear bits in both directions. Each such word tells apart a design that follows the level of a bit, one that reacts to the wrong edge, and one that detects the correct edge. Releasing a reset word straight after block reset (writing 0 onto 0) separates a design that compares against the previous word from one that compares against the line state. Writes to the first and last word of each group, to the neighbouring plain words, and to addresses with nonzero low bits check the line numbering and the index decode. A long pseudo-random mix of reads and writes over the whole address space, including out-of-range words, is checked every cycle against a behavioural model.

// File: rtl/gate_bank_pkg.sv
package gate_bank_pkg;

  // Strobes that the control half hands to the datapath in the request cycle.
  typedef struct packed {
    logic wrCommit;   // in-range write is committed at this edge
    logic rdCommit;   // in-range read is captured at this edge
    logic rangeErr;   // request addresses a word beyond the bank
  } bankStrobes_t;

endpackage

// File: rtl/gate_bank_ctrl.sv
module gate_bank_ctrl
  import gate_bank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_COUNT = 24,
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output bankStrobes_t     strobes,
  output logic [IDX_W-1:0] regIndex,
  output logic             respValid,
  output logic             respErr
);

  localparam logic [IDX_W:0] IDX_LIMIT = (IDX_W+1)'(REG_COUNT);

  logic inRange;
  logic unusedByteLane;

  assign regIndex       = reqAddr[ADDR_W-1:2];
  assign unusedByteLane = ^reqAddr[1:0];
  assign inRange        = ({1'b0, regIndex} < IDX_LIMIT);

  always_comb begin
    strobes          = '0;
    strobes.wrCommit = reqValid &  reqWrite & inRange;
    strobes.rdCommit = reqValid & ~reqWrite & inRange;
    strobes.rangeErr = reqValid & ~inRange;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respErr   <= 1'b0;
    end else begin
      respValid <= reqValid;
      respErr   <= strobes.rangeErr;
    end
  end

  // R2: every request is answered in the following cycle
  p_resp_tracks_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (respValid == $past(reqValid)));

  // R3: the error flag only ever travels with a response
  p_err_needs_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    respErr |-> respValid);

endmodule

// File: rtl/gate_line_group.sv
module gate_line_group #(
  parameter int  DATA_W      = 32,
  parameter int  ADDR_W      = 8,
  parameter int  GRP_REGS    = 5,
  parameter int  GRP_BASE    = 4,
  parameter bit  SET_ON_RISE = 1'b0,
  parameter bit  LINE_INIT   = 1'b1,
  localparam int IDX_W       = ADDR_W - 2,
  localparam int LINES       = GRP_REGS * DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrCommit,
  input  logic [IDX_W-1:0] regIndex,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LINES-1:0] oldWords,
  output logic [LINES-1:0] lines
);

  logic [GRP_REGS-1:0] wordHit;
  logic                groupHit;

  for (genvar g = 0; g < GRP_REGS; g++) begin : g_word
    logic [DATA_W-1:0] oldWord;
    logic [DATA_W-1:0] edgeMask;

    assign wordHit[g] = wrCommit && (regIndex == IDX_W'(GRP_BASE + g));
    assign oldWord    = oldWords[g*DATA_W +: DATA_W];

    if (SET_ON_RISE) begin : g_rise
      assign edgeMask = ~oldWord & wrData;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          lines[g*DATA_W +: DATA_W] <= {DATA_W{LINE_INIT}};
        else if (wordHit[g]) lines[g*DATA_W +: DATA_W] <= lines[g*DATA_W +: DATA_W] | edgeMask;
      end
    end else begin : g_fall
      assign edgeMask = oldWord & ~wrData;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          lines[g*DATA_W +: DATA_W] <= {DATA_W{LINE_INIT}};
        else if (wordHit[g]) lines[g*DATA_W +: DATA_W] <= lines[g*DATA_W +: DATA_W] & ~edgeMask;
      end
    end
  end

  assign groupHit = |wordHit;

  if (SET_ON_RISE) begin : g_chk_rise
    // R7: enable lines are sticky high
    p_en_line_no_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~lines & $past(lines)) == '0));
  end else begin : g_chk_fall
    // R5: reset lines are sticky low
    p_rst_line_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lines & ~$past(lines)) == '0));
  end

  // R9: lines hold when no write lands in this group
  p_idle_group_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !groupHit |=> $stable(lines));

endmodule

// File: rtl/gate_bank_dpath.sv
module gate_bank_dpath
  import gate_bank_pkg::*;
#(
  parameter int  DATA_W    = 32,
  parameter int  ADDR_W    = 8,
  parameter int  REG_COUNT = 24,
  parameter int  RST_BASE  = 4,
  parameter int  RST_REGS  = 5,
  parameter int  EN_BASE   = 12,
  parameter int  EN_REGS   = 5,
  parameter bit  RST_INIT  = 1'b1,
  localparam int IDX_W     = ADDR_W - 2,
  localparam int RST_LINES = RST_REGS * DATA_W,
  localparam int EN_LINES  = EN_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bankStrobes_t      strobes,
  input  logic [IDX_W-1:0]  regIndex,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [RST_LINES-1:0] rstLines,
  output logic [EN_LINES-1:0]  enLines
);

  logic [DATA_W-1:0]    regBank [REG_COUNT];
  logic [DATA_W-1:0]    rdSel;
  logic [RST_LINES-1:0] rstOld;
  logic [EN_LINES-1:0]  enOld;

  for (genvar k = 0; k < REG_COUNT; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regBank[k] <= '0;
      else if (strobes.wrCommit && (regIndex == IDX_W'(k)))
        regBank[k] <= wrData;
    end
  end

  for (genvar g = 0; g < RST_REGS; g++) begin : g_rst_old
    assign rstOld[g*DATA_W +: DATA_W] = regBank[RST_BASE + g];
  end

  for (genvar g = 0; g < EN_REGS; g++) begin : g_en_old
    assign enOld[g*DATA_W +: DATA_W] = regBank[EN_BASE + g];
  end

  gate_line_group #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .GRP_REGS(RST_REGS), .GRP_BASE(RST_BASE),
    .SET_ON_RISE(1'b0), .LINE_INIT(RST_INIT)
  ) u_rstGroup (
    .clk(clk), .rst_n(rst_n), .wrCommit(strobes.wrCommit), .regIndex(regIndex),
    .wrData(wrData), .oldWords(rstOld), .lines(rstLines)
  );

  gate_line_group #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .GRP_REGS(EN_REGS), .GRP_BASE(EN_BASE),
    .SET_ON_RISE(1'b1), .LINE_INIT(1'b0)
  ) u_enGroup (
    .clk(clk), .rst_n(rst_n), .wrCommit(strobes.wrCommit), .regIndex(regIndex),
    .wrData(wrData), .oldWords(enOld), .lines(enLines)
  );

  always_comb begin
    rdSel = '0;
    for (int k = 0; k < REG_COUNT; k++) begin
      if (regIndex == IDX_W'(k)) rdSel = regBank[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdData <= '0;
    else if (strobes.rdCommit) rdData <= rdSel;
    else                       rdData <= '0;
  end

  // R3: out-of-range reads answer with zero data
  p_oor_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rangeErr |=> (rdData == '0));

endmodule

// File: rtl/periph_gate_bank.sv
module periph_gate_bank
  import gate_bank_pkg::*;
#(
  parameter int  DATA_W    = 32,
  parameter int  ADDR_W    = 8,
  parameter int  REG_COUNT = 24,
  parameter int  RST_BASE  = 4,
  parameter int  RST_REGS  = 5,
  parameter int  EN_BASE   = 12,
  parameter int  EN_REGS   = 5,
  parameter bit  RST_INIT  = 1'b1,
  localparam int IDX_W     = ADDR_W - 2,
  localparam int RST_LINES = RST_REGS * DATA_W,
  localparam int EN_LINES  = EN_REGS * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 respValid,
  output logic                 respErr,
  output logic [DATA_W-1:0]    respRdata,
  output logic [RST_LINES-1:0] rstLines,
  output logic [EN_LINES-1:0]  enLines
);

  bankStrobes_t     strobes;
  logic [IDX_W-1:0] regIndex;

  gate_bank_ctrl #(.ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .strobes(strobes), .regIndex(regIndex),
    .respValid(respValid), .respErr(respErr)
  );

  gate_bank_dpath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT),
    .RST_BASE(RST_BASE), .RST_REGS(RST_REGS), .EN_BASE(EN_BASE),
    .EN_REGS(EN_REGS), .RST_INIT(RST_INIT)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .regIndex(regIndex),
    .wrData(reqWdata), .rdData(respRdata), .rstLines(rstLines), .enLines(enLines)
  );

endmodule

// File: tb/periph_gate_bank_bench.sv
module periph_gate_bank_bench;

  localparam int NREG = 24;
  localparam int RB = 4;
  localparam int EB = 12;
  localparam int GR = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic [7:0]   reqAddr = '0;
  logic [31:0]  reqWdata = '0;
  logic         respValid;
  logic         respErr;
  logic [31:0]  respRdata;
  logic [159:0] rstLines;
  logic [159:0] enLines;

  always #10 clk = ~clk;

  periph_gate_bank u_periph_gate_bank (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .respValid(respValid),
    .respErr(respErr), .respRdata(respRdata), .rstLines(rstLines), .enLines(enLines)
  );

  // behavioural reference state
  bit [31:0]  mRegs [NREG];
  bit [159:0] mRst = '1;
  bit [159:0] mEn  = '0;
  bit         eValid = 1'b0;
  bit         eErr   = 1'b0;
  bit [31:0]  eData  = '0;
  int         checks = 0;
  int         fails  = 0;
  string      curTag = "R1";
  bit [31:0]  seed = 32'h1234_5678;

  task automatic note_fail(input string what, input logic [159:0] act, input logic [159:0] exp);
    fails++;
    $display("FAIL %s %s: actual %h expected %h", curTag, what, act, exp);
  endtask

  task automatic compare_all();
    checks++;
    if (respValid !== eValid) note_fail("respValid", 160'(respValid), 160'(eValid));
    else if (eValid && respErr !== eErr) note_fail("respErr", 160'(respErr), 160'(eErr));
    else if (eValid && respRdata !== eData) note_fail("respRdata", 160'(respRdata), 160'(eData));
    checks++;
    if (rstLines !== mRst) note_fail("rstLines", rstLines, mRst);
    checks++;
    if (enLines !== mEn) note_fail("enLines", enLines, mEn);
  endtask

  task automatic model_apply(input bit v, input bit w, input bit [7:0] a, input bit [31:0] d);
    int idx;
    idx    = int'(a >> 2);
    eValid = v;
    eErr   = 1'b0;
    eData  = '0;
    if (v) begin
      if (idx >= NREG) eErr = 1'b1;
      else if (!w) eData = mRegs[idx];
      else begin
        for (int b = 0; b < 32; b++) begin
          if (idx >= RB && idx < RB + GR && mRegs[idx][b] && !d[b]) mRst[(idx-RB)*32+b] = 1'b0;
          if (idx >= EB && idx < EB + GR && !mRegs[idx][b] && d[b]) mEn[(idx-EB)*32+b] = 1'b1;
        end
        mRegs[idx] = d;
      end
    end
  endtask

  task automatic step(input bit v, input bit w, input bit [7:0] a, input bit [31:0] d);
    @(negedge clk);
    compare_all();
    reqValid = v;
    reqWrite = w;
    reqAddr  = a;
    reqWdata = d;
    model_apply(v, w, a, d);
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    step(1'b1, 1'b1, a, d);
  endtask

  task automatic rd(input bit [7:0] a);
    step(1'b1, 1'b0, a, '0);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, '0, '0);
  endtask

  function automatic bit [31:0] next_rand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NREG; k++) mRegs[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    curTag = "R1";
    idle(); idle();
    for (int k = 0; k < NREG; k++) rd(8'(k*4));

    curTag = "R10";
    wr(8'h10, 32'h0);
    wr(8'h10, 32'h0);
    idle();

    curTag = "R5";
    wr(8'h10, 32'hFFFF_FFFF);
    idle();
    curTag = "R4";
    wr(8'h10, 32'hA5A5_A5A5);
    curTag = "R8";
    rd(8'h10);
    curTag = "R5";
    wr(8'h10, 32'hFFFF_FFFF);
    curTag = "R4";
    wr(8'h20, 32'h8000_0000);
    wr(8'h20, 32'h0000_0000);
    wr(8'h14, 32'hFFFF_0000);
    wr(8'h14, 32'h00FF_FF00);
    curTag = "R10";
    wr(8'h14, 32'h00FF_FF00);

    curTag = "R6";
    wr(8'h30, 32'h0000_00F0);
    curTag = "R7";
    wr(8'h30, 32'h0000_0000);
    curTag = "R6";
    wr(8'h30, 32'h0000_000F);
    wr(8'h40, 32'h8000_0001);
    curTag = "R7";
    wr(8'h40, 32'h0000_0001);
    curTag = "R8";
    rd(8'h40);

    curTag = "R2";
    wr(8'h37, 32'h0001_0000);
    rd(8'h35);
    rd(8'h36);
    idle();

    curTag = "R9";
    wr(8'h00, 32'hDEAD_BEEF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h2C, 32'h0);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h5C, 32'h1357_9BDF);
    rd(8'h00); rd(8'h24); rd(8'h44); rd(8'h5C);

    curTag = "R3";
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'hFC, 32'h0);
    rd(8'h60);
    rd(8'hFF);
    rd(8'h5C);
    idle();

    curTag = "R8";
    for (int n = 0; n < 400; n++) begin
      bit [31:0] r;
      bit [7:0]  a;
      r = next_rand();
      a = 8'(((r % 26) << 2) | (r >> 30));
      if (r[20]) wr(a, next_rand() & next_rand());
      else if (r[21]) rd(a);
      else wr(a, next_rand() | next_rand());
      if (r[3:0] == 4'd0) idle();
    end
    idle(); idle();
    finish_run();
  end

endmodule